// File: doc/BRIEF.md
# Banked Coefficient Register File

This block stores the coefficient sets and the mode settings for a two-channel, eight-tap filter. A 10-bit value is written at a 9-bit address on the rising edge of a write strobe. The strobe is sampled with the master clock, so a write happens on the clock edge where the strobe is first seen high. The lower part of the address space holds 32 banks of eight coefficients. Two addresses above that region hold one mode register per channel. All other addresses are ignored.

On every master clock edge a 5-bit bank select is registered. The eight coefficients of the chosen bank then drive the tap multipliers of both channels in parallel. A write to the bank that is currently selected shows up on the tap bus after the same edge. A flag derived from both mode registers tells the downstream arithmetic whether the filter result is unsigned.

Top module: `coef_bank_regfile`

## Requirements
- R1: After reset, every stored coefficient is 0, both mode outputs are 0, the registered bank select is 0 and out_unsigned is 0.
- R2: On a clock edge where wr_stb is high and was low on the previous edge, a wr_addr below 256 writes wr_data into bank wr_addr[7:3], tap wr_addr[2:0].
- R3: A strobe that stays high for several edges performs one write only, on its first high edge. Data or address changes while the strobe is held high have no effect.
- R4: coef_sel is captured on each rising clock edge. The tap bus shows the bank captured at the most recent edge, and changes of coef_sel between edges do not affect it.
- R5: All eight coefficients of the selected bank appear at once on coef_taps, with tap t on bits [10t+9:10t].
- R6: A write to address 256 loads mode_a and a write to address 257 loads mode_b, each from wr_data[3:0]. The field layout is: bit 0 = data signed, bit 1 = coefficient signed, bits 3:2 = symmetry (00 none, 01 even, 10 odd). wr_data[9:4] is discarded.
- R7: Writes to addresses 258 to 511 change neither a coefficient nor a mode register.
- R8: out_unsigned is 1 exactly when both mode registers hold even symmetry with both sign bits clear (value 4'b0100). Otherwise it is 0.
- R9: When a write to a bank and a change of the bank select fall on the same edge, the tap bus after that edge shows the newly selected bank, and that bank includes the write if it was the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Write strobe; a write happens on its rising edge |
| wr_addr | input | 9 | Write address |
| wr_data | input | 10 | Write data |
| coef_sel | input | 5 | Bank select, registered each clock |
| coef_taps | output | 80 | Eight 10-bit coefficients of the selected bank |
| mode_a | output | 4 | Mode register for channel A |
| mode_b | output | 4 | Mode register for channel B |
| out_unsigned | output | 1 | High when the filter output is unsigned |

## Verification
A coefficient write and a bank switch can land on the same clock edge. This matters most when the write targets the bank being switched to or away from. The bench raises the strobe on the same edge where coef_sel moves to the target bank, and again where it moves away. The scoreboard's own memory model predicts the whole tap bus after that edge, so a stale read or a write that lands one cycle late is reported.

// File: rtl/coef_bank_pkg.sv
package coef_bank_pkg;
  typedef enum logic [1:0] {
    SYM_NONE = 2'b00,
    SYM_EVEN = 2'b01,
    SYM_ODD  = 2'b10,
    SYM_RSVD = 2'b11
  } sym_e;

  typedef struct packed {
    sym_e sym;
    logic coef_sgn;
    logic data_sgn;
  } mode_t;

  function automatic logic unsigned_result(input mode_t a, input mode_t b);
    logic a_ok, b_ok;
    a_ok = (a.sym == SYM_EVEN) && !a.coef_sgn && !a.data_sgn;
    b_ok = (b.sym == SYM_EVEN) && !b.coef_sgn && !b.data_sgn;
    return a_ok && b_ok;
  endfunction
endpackage

// File: rtl/wr_decode.sv
module wr_decode #(
  parameter int AW        = 9,
  parameter int SELW      = 5,
  parameter int TAPW      = 3,
  parameter int CTRL_BASE = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_stb,
  input  logic [AW-1:0]   wr_addr,
  output logic            wr_fire,
  output logic            bank_we,
  output logic [SELW-1:0] bank_idx,
  output logic [TAPW-1:0] tap_idx,
  output logic            ctrl_we_a,
  output logic            ctrl_we_b
);
  logic stb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= wr_stb;
  end

  assign wr_fire   = wr_stb && !stb_q;
  assign bank_idx  = wr_addr[TAPW +: SELW];
  assign tap_idx   = wr_addr[TAPW-1:0];
  assign bank_we   = wr_fire && (wr_addr <  AW'(CTRL_BASE));
  assign ctrl_we_a = wr_fire && (wr_addr == AW'(CTRL_BASE));
  assign ctrl_we_b = wr_fire && (wr_addr == AW'(CTRL_BASE + 1));

  // R3
  single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_fire);

  // R7
  decode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bank_we, ctrl_we_a, ctrl_we_b}));
endmodule

// File: rtl/coef_bank_array.sv
module coef_bank_array #(
  parameter int CW    = 10,
  parameter int TAPS  = 8,
  parameter int BANKS = 32,
  parameter int SELW  = 5,
  parameter int TAPW  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [SELW-1:0]    bank_idx,
  input  logic [TAPW-1:0]    tap_idx,
  input  logic [CW-1:0]      wdata,
  input  logic [SELW-1:0]    rd_sel,
  output logic [TAPS*CW-1:0] taps
);
  logic [CW-1:0] mem [BANKS][TAPS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < BANKS; b++)
        for (int t = 0; t < TAPS; t++)
          mem[b][t] <= '0;
    end else if (we) begin
      mem[bank_idx][tap_idx] <= wdata;
    end
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign taps[t*CW +: CW] = mem[rd_sel][t];
  end

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(bank_idx)][$past(tap_idx)] == $past(wdata));
endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
  import coef_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_a,
  input  logic       we_b,
  input  logic [3:0] wdata,
  output logic [3:0] mode_a,
  output logic [3:0] mode_b,
  output logic       out_unsigned
);
  mode_t reg_a, reg_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_a <= '0;
      reg_b <= '0;
    end else begin
      if (we_a) reg_a <= mode_t'(wdata);
      if (we_b) reg_b <= mode_t'(wdata);
    end
  end

  assign mode_a       = reg_a;
  assign mode_b       = reg_b;
  assign out_unsigned = unsigned_result(reg_a, reg_b);

  // R6
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_a |=> mode_a == $past(wdata));

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_a && !we_b |=> $stable(mode_a) && $stable(mode_b));
endmodule

// File: rtl/coef_bank_regfile.sv
module coef_bank_regfile #(
  parameter int CW    = 10,
  parameter int AW    = 9,
  parameter int TAPS  = 8,
  parameter int BANKS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [8:0]         wr_addr,
  input  logic [9:0]         wr_data,
  input  logic [4:0]         coef_sel,
  output logic [79:0]        coef_taps,
  output logic [3:0]         mode_a,
  output logic [3:0]         mode_b,
  output logic               out_unsigned
);
  localparam int SELW      = $clog2(BANKS);
  localparam int TAPW      = $clog2(TAPS);
  localparam int CTRL_BASE = BANKS * TAPS;

  logic            wr_fire, bank_we, ctrl_we_a, ctrl_we_b;
  logic [SELW-1:0] bank_idx, sel_q;
  logic [TAPW-1:0] tap_idx;
  logic            past_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      past_ok <= 1'b0;
    end else begin
      sel_q   <= coef_sel;
      past_ok <= 1'b1;
    end
  end

  wr_decode #(.AW(AW), .SELW(SELW), .TAPW(TAPW), .CTRL_BASE(CTRL_BASE)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_fire(wr_fire), .bank_we(bank_we), .bank_idx(bank_idx), .tap_idx(tap_idx),
    .ctrl_we_a(ctrl_we_a), .ctrl_we_b(ctrl_we_b)
  );

  coef_bank_array #(.CW(CW), .TAPS(TAPS), .BANKS(BANKS), .SELW(SELW), .TAPW(TAPW)) u_banks (
    .clk(clk), .rst_n(rst_n), .we(bank_we), .bank_idx(bank_idx), .tap_idx(tap_idx),
    .wdata(wr_data), .rd_sel(sel_q), .taps(coef_taps)
  );

  ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n), .we_a(ctrl_we_a), .we_b(ctrl_we_b),
    .wdata(wr_data[3:0]), .mode_a(mode_a), .mode_b(mode_b), .out_unsigned(out_unsigned)
  );

  // R4
  taps_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !wr_fire && (coef_sel == sel_q) |=> $stable(coef_taps));

  // R7
  unmapped_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && (wr_addr > AW'(CTRL_BASE + 1)) |=> $stable(mode_a) && $stable(mode_b) && $stable(coef_taps) || $past(coef_sel) != $past(sel_q));

  // R8
  unsigned_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_unsigned |-> (mode_a == 4'b0100) && (mode_b == 4'b0100));
endmodule

// File: tb/tb_coef_bank_regfile.sv
module tb_coef_bank_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [8:0]  wr_addr = '0;
  logic [9:0]  wr_data = '0;
  logic [4:0]  coef_sel = '0;
  logic [79:0] coef_taps;
  logic [3:0]  mode_a, mode_b;
  logic        out_unsigned;

  always #2.5 clk = ~clk;

  coef_bank_regfile dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .coef_sel(coef_sel), .coef_taps(coef_taps), .mode_a(mode_a), .mode_b(mode_b),
    .out_unsigned(out_unsigned)
  );

  typedef struct {
    logic [79:0] taps;
    logic [3:0]  ma, mb;
    logic        uns;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0, n_fail = 0;
  logic [9:0]  m_mem [256];
  logic [3:0]  m_ma = '0, m_mb = '0;
  logic [4:0]  m_sel = '0;
  logic        m_prev = 1'b0;
  bit          done = 1'b0;

  function automatic logic [79:0] bank_word(input logic [4:0] b);
    logic [79:0] w;
    for (int t = 0; t < 8; t++) w[t*10 +: 10] = m_mem[b*8 + t];
    return w;
  endfunction

  task automatic cmp(input string tag, input string what, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: one clock step, model update, push expectation
  task automatic step(input string tag);
    exp_t e;
    @(posedge clk);
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) m_mem[i] = '0;
      m_ma = '0; m_mb = '0; m_sel = '0; m_prev = 1'b0;
    end else begin
      if (wr_stb && !m_prev) begin
        if (wr_addr < 9'd256)       m_mem[wr_addr[7:0]] = wr_data;
        else if (wr_addr == 9'd256) m_ma = wr_data[3:0];
        else if (wr_addr == 9'd257) m_mb = wr_data[3:0];
      end
      m_prev = wr_stb;
      m_sel  = coef_sel;
    end
    e.taps = bank_word(m_sel);
    e.ma = m_ma; e.mb = m_mb;
    e.uns = (m_ma == 4'b0100) && (m_mb == 4'b0100);
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      cmp(e.tag, "taps", coef_taps, e.taps);
      cmp(e.tag, "mode_a", 80'(mode_a), 80'(e.ma));
      cmp(e.tag, "mode_b", 80'(mode_b), 80'(e.mb));
      cmp(e.tag, "unsigned", 80'(out_unsigned), 80'(e.uns));
    end
  end

  task automatic wr(input string tag, input logic [8:0] a, input logic [9:0] d);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    step(tag);
    wr_stb = 1'b0;
    step(tag);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) m_mem[i] = 'x;
    @(negedge clk);
    step("R1"); step("R1");
    rst_n = 1'b1;
    step("R1");

    // R2 R5: fill bank 3, then select it
    for (int t = 0; t < 8; t++) wr("R2", 9'(3*8 + t), 10'(10'h2A0 + t*37));
    coef_sel = 5'd3;
    step("R5");

    // R4: change select between edges, tap bus holds until next edge
    coef_sel = 5'd0;
    #1;
    cmp("R4", "taps between edges", coef_taps, bank_word(5'd3));
    step("R4");
    coef_sel = 5'd3;
    step("R4");

    // R3: strobe held high while data and address change
    wr_stb = 1'b1; wr_addr = 9'd26; wr_data = 10'h155;
    step("R3");
    wr_data = 10'h0AA; step("R3");
    wr_addr = 9'd27; wr_data = 10'h3FF; step("R3");
    wr_stb = 1'b0; step("R3");

    // R6: mode registers, upper data bits discarded
    wr("R6", 9'd256, 10'h3F6);
    wr("R6", 9'd257, 10'h2C9);

    // R7: unmapped writes, 258 would alias bank 0 tap 2 if decoded loosely
    coef_sel = 5'd0; step("R7");
    wr("R7", 9'd258, 10'h111);
    wr("R7", 9'd383, 10'h222);
    wr("R7", 9'd511, 10'h333);

    // R8: unsigned flag combinations
    wr("R8", 9'd256, 10'h004);
    wr("R8", 9'd257, 10'h004);
    wr("R8", 9'd257, 10'h005);
    wr("R8", 9'd257, 10'h008);
    wr("R8", 9'd257, 10'h004);
    wr("R8", 9'd256, 10'h006);

    // R9: write and bank switch on the same edge
    wr_stb = 1'b1; wr_addr = 9'd9*8 + 9'd5; wr_data = 10'h1E7; coef_sel = 5'd9;
    step("R9");
    wr_stb = 1'b0; step("R9");
    wr_stb = 1'b1; wr_addr = 9'd9*8 + 9'd1; wr_data = 10'h0C3; coef_sel = 5'd3;
    step("R9");
    wr_stb = 1'b0; coef_sel = 5'd9; step("R9");

    step("end");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule